// File: doc/BRIEF.md
# Reference-relative tilt ASCII formatter

This block turns raw 8-bit inclination readings from an external converter into text that a character display can print directly. The converter code is proportional to the sensor voltage (code = 256 * Vin / Vref). One code step is one degree, so readings span 0 to 255 degrees.

A calibrate strobe given together with a sample makes that sample the zero point. Every later sample is reported as its distance above that zero point. A reading below the zero point is clamped to 0.

The difference is converted to three zero-padded decimal digits by a sequential shift-and-correct binary-to-BCD engine. The digits are presented as ASCII bytes next to a constant fraction field. A one-cycle flag marks each fresh result. Samples offered while a conversion is running are dropped.

Top module: `tilt_ascii_fmt`

## Requirements
- R1: While `rst_n` is low and after its release, `res_valid` is 0, each of `hund_ascii`, `tens_ascii` and `unit_ascii` is 8'h30, and the stored zero point is 0.
- R2: A sample accepted without `calib` yields the value `samp - zero_point` whenever `samp` is at or above the zero point.
- R3: A sample accepted without `calib` that lies below the zero point yields 0. The result never wraps.
- R4: A sample accepted with `calib` high becomes the new zero point, and its own result is 0.
- R5: Each digit byte is its decimal digit plus 8'h30. The result is split as hundreds, tens and units with leading zeros. `frac_ascii` always reads ".00", that is 8'h2E in bits 23:16 and 8'h30 in bits 15:8 and 7:0.
- R6: A sample is accepted on a rising edge where `samp_vld` is high and no conversion is running. `res_valid` is then high for exactly one cycle, after the 8th rising edge that follows the accepting edge.
- R7: A `samp_vld` pulse during a running conversion is ignored, whatever `calib` and `samp` carry. The zero point is unchanged and no extra result is produced.
- R8: `calib` without `samp_vld` has no effect on the zero point.
- R9: The digit outputs change only when a new result is flagged. Otherwise they hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| calib | input | 1 | Take the accompanying sample as the zero point |
| samp | input | 8 | Converter code |
| samp_vld | input | 1 | Sample present this cycle |
| hund_ascii | output | 8 | ASCII hundreds digit |
| tens_ascii | output | 8 | ASCII tens digit |
| unit_ascii | output | 8 | ASCII units digit |
| frac_ascii | output | 24 | Constant ".00" fraction text |
| res_valid | output | 1 | One-cycle flag for a new result |

## Verification
The bench instantiates the block with its default sample width of 8. This makes the whole 0 to 255 range reachable, including the extremes 255 and 0 and a result whose hundreds digit is 2. It also gives the exact eight-step conversion latency, so the flag position can be counted to the cycle. With this width, zero points at 0, in the middle of the range and at 255 can all be tried. A conversion is long enough to inject a competing sample in its middle.

// File: rtl/tilt_fmt_pkg.sv
// Shared constants and helpers for the tilt formatter.
// Assumes ASCII digit encoding, where '0' is 8'h30.
package tilt_fmt_pkg;
    localparam logic [7:0] ASC_ZERO = 8'h30;
    localparam logic [7:0] ASC_DOT  = 8'h2E;

    typedef enum logic {CV_IDLE, CV_RUN} conv_state_t;

    // Map one BCD nibble to its ASCII character.
    function automatic logic [7:0] nib_to_ascii(input logic [3:0] nib);
        return ASC_ZERO + {4'h0, nib};
    endfunction
endpackage

// File: rtl/tilt_ref_sub.sv
// Holds the calibration zero point and forms the clamped difference.
// Assumes 'take' is high only on an edge where a sample is accepted.
// With calib high the difference is forced to 0 and the sample is latched.
module tilt_ref_sub #(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic                calib,
    input  logic [SAMPLE_W-1:0] samp,
    output logic [SAMPLE_W-1:0] rel
);
    logic [SAMPLE_W-1:0] zero_q;

    // Latch a new zero point on an accepted calibration sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            zero_q <= '0;
        else if (take && calib)
            zero_q <= samp;
    end

    // Clamp at 0 below the zero point; calibration reads as 0.
    always_comb begin
        if (calib || samp < zero_q)
            rel = '0;
        else
            rel = samp - zero_q;
    end
endmodule

// File: rtl/tilt_bcd_seq.sv
// Sequential shift-and-add-3 binary to BCD converter.
// Takes SAMPLE_W steps after the starting edge. 'done' pulses on the edge
// that writes the result, which is then held until the next result.
// Assumes 'start' is ignored while busy.
module tilt_bcd_seq
    import tilt_fmt_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int DIGITS   = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [SAMPLE_W-1:0]   bin_in,
    output logic                  busy,
    output logic                  done,
    output logic [4*DIGITS-1:0]   bcd_out
);
    localparam int BCD_W = 4 * DIGITS;
    localparam int CNT_W = $clog2(SAMPLE_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_W - 1);

    conv_state_t             st_q;
    logic [CNT_W-1:0]        cnt_q;
    logic [SAMPLE_W-1:0]     bin_q;
    logic [BCD_W-1:0]        work_q;
    logic [BCD_W-1:0]        adj;
    logic [BCD_W+SAMPLE_W-1:0] shifted;

    // Correct every nibble of 5 or more by adding 3 before the shift.
    for (genvar d = 0; d < DIGITS; d++) begin : g_adj
        always_comb begin
            if (work_q[4*d +: 4] >= 4'd5)
                adj[4*d +: 4] = work_q[4*d +: 4] + 4'd3;
            else
                adj[4*d +: 4] = work_q[4*d +: 4];
        end
    end

    // One step: the corrected digits and the binary bits move left together.
    assign shifted = {adj, bin_q} << 1;
    assign busy    = (st_q == CV_RUN);

    // Step sequencer, working registers and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= CV_IDLE;
            cnt_q   <= '0;
            bin_q   <= '0;
            work_q  <= '0;
            bcd_out <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st_q)
                CV_IDLE: begin
                    if (start) begin
                        bin_q  <= bin_in;
                        work_q <= '0;
                        cnt_q  <= '0;
                        st_q   <= CV_RUN;
                    end
                end
                CV_RUN: begin
                    bin_q  <= shifted[SAMPLE_W-1:0];
                    work_q <= shifted[BCD_W+SAMPLE_W-1:SAMPLE_W];
                    cnt_q  <= cnt_q + 1'b1;
                    if (cnt_q == LAST) begin
                        bcd_out <= shifted[BCD_W+SAMPLE_W-1:SAMPLE_W];
                        done    <= 1'b1;
                        st_q    <= CV_IDLE;
                    end
                end
                default: st_q <= CV_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tilt_ascii_enc.sv
// Turns packed BCD digits into ASCII bytes, least significant digit first.
// Assumes every nibble already holds a value from 0 to 9.
module tilt_ascii_enc
    import tilt_fmt_pkg::*;
#(
    parameter int DIGITS = 3
) (
    input  logic [4*DIGITS-1:0] bcd,
    output logic [8*DIGITS-1:0] ascii
);
    // One character per digit position.
    for (genvar d = 0; d < DIGITS; d++) begin : g_chr
        assign ascii[8*d +: 8] = nib_to_ascii(bcd[4*d +: 4]);
    end
endmodule

// File: rtl/tilt_ascii_fmt.sv
// Top level: zero-point subtraction, BCD conversion and ASCII output.
// A sample is taken on samp_vld when no conversion is running; others drop.
// Assumes SAMPLE_W is between 2 and 9, so three digits always suffice.
module tilt_ascii_fmt
    import tilt_fmt_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                calib,
    input  logic [SAMPLE_W-1:0] samp,
    input  logic                samp_vld,
    output logic [7:0]          hund_ascii,
    output logic [7:0]          tens_ascii,
    output logic [7:0]          unit_ascii,
    output logic [23:0]         frac_ascii,
    output logic                res_valid
);
    localparam int DIGITS = 3;

    logic                  busy;
    logic                  take;
    logic [SAMPLE_W-1:0]   rel;
    logic [4*DIGITS-1:0]   bcd;
    logic [8*DIGITS-1:0]   chars;

    // Accept only when the converter is free.
    assign take = samp_vld && !busy;

    tilt_ref_sub #(.SAMPLE_W(SAMPLE_W)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .calib (calib),
        .samp  (samp),
        .rel   (rel)
    );

    tilt_bcd_seq #(.SAMPLE_W(SAMPLE_W), .DIGITS(DIGITS)) u_bcd (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (take),
        .bin_in  (rel),
        .busy    (busy),
        .done    (res_valid),
        .bcd_out (bcd)
    );

    tilt_ascii_enc #(.DIGITS(DIGITS)) u_enc (
        .bcd   (bcd),
        .ascii (chars)
    );

    // Split characters onto the digit ports; the fraction text is fixed.
    assign unit_ascii = chars[7:0];
    assign tens_ascii = chars[15:8];
    assign hund_ascii = chars[23:16];
    assign frac_ascii = {ASC_DOT, ASC_ZERO, ASC_ZERO};
endmodule

// File: rtl/tilt_ascii_fmt_chk.sv
// Property checker for tilt_ascii_fmt, attached through bind.
// It tracks acceptance from the ports with its own counter.
module tilt_ascii_fmt_chk #(
    parameter int SAMPLE_W = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        calib,
    input logic        samp_vld,
    input logic [7:0]  hund_ascii,
    input logic [7:0]  tens_ascii,
    input logic [7:0]  unit_ascii,
    input logic        res_valid
);
    localparam int CW = $clog2(SAMPLE_W + 2);
    logic          act_q;
    logic          zpend_q;
    logic [CW-1:0] cnt_q;

    // Track a running conversion and whether it was a calibration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            zpend_q <= 1'b0;
            cnt_q   <= '0;
        end else if (!act_q && samp_vld) begin
            act_q   <= 1'b1;
            zpend_q <= calib;
            cnt_q   <= '0;
        end else if (act_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(SAMPLE_W - 1))
                act_q <= 1'b0;
        end
    end

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R6
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (cnt_q == CW'(SAMPLE_W) && !act_q));

    // R4
    calib_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && zpend_q) |->
        (hund_ascii == 8'h30 && tens_ascii == 8'h30 && unit_ascii == 8'h30));

    // R9
    digits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(hund_ascii) && $stable(tens_ascii) && $stable(unit_ascii)));

    // R5
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (hund_ascii >= 8'h30 && hund_ascii <= 8'h39 &&
                       tens_ascii >= 8'h30 && tens_ascii <= 8'h39 &&
                       unit_ascii >= 8'h30 && unit_ascii <= 8'h39));
endmodule

bind tilt_ascii_fmt tilt_ascii_fmt_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .calib      (calib),
    .samp_vld   (samp_vld),
    .hund_ascii (hund_ascii),
    .tens_ascii (tens_ascii),
    .unit_ascii (unit_ascii),
    .res_valid  (res_valid)
);

// File: tb/tilt_ascii_fmt_tb.sv
module tilt_ascii_fmt_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        calib = 1'b0;
    logic [7:0]  samp = '0;
    logic        samp_vld = 1'b0;
    logic [7:0]  hund_ascii, tens_ascii, unit_ascii;
    logic [23:0] frac_ascii;
    logic        res_valid;
    int          total = 0;
    int          bad = 0;

    always #2.5 clk = ~clk;

    tilt_ascii_fmt u_dut (
        .clk(clk), .rst_n(rst_n), .calib(calib), .samp(samp),
        .samp_vld(samp_vld), .hund_ascii(hund_ascii), .tens_ascii(tens_ascii),
        .unit_ascii(unit_ascii), .frac_ascii(frac_ascii), .res_valid(res_valid)
    );

    // {calib, sample, expected degrees}; the zero point carries over between rows
    localparam logic [16:0] VEC [13] = '{
        {1'b0, 8'd7,   8'd7},    // R2 zero point 0
        {1'b0, 8'd37,  8'd37},   // R2
        {1'b0, 8'd113, 8'd113},  // R2
        {1'b0, 8'd255, 8'd255},  // R2 top of range
        {1'b0, 8'd0,   8'd0},    // R2 bottom
        {1'b1, 8'd100, 8'd0},    // R4 zero point 100
        {1'b0, 8'd119, 8'd19},   // R2
        {1'b0, 8'd99,  8'd0},    // R3 below zero point
        {1'b0, 8'd255, 8'd155},  // R2
        {1'b1, 8'd255, 8'd0},    // R4 zero point 255
        {1'b0, 8'd254, 8'd0},    // R3
        {1'b1, 8'd0,   8'd0},    // R4 zero point 0
        {1'b0, 8'd200, 8'd200}   // R2
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_digits(input int v, input string tag);
        check(hund_ascii == 8'(v / 100 + 48), tag, hund_ascii, v / 100 + 48);
        check(tens_ascii == 8'((v / 10) % 10 + 48), tag, tens_ascii, (v / 10) % 10 + 48);
        check(unit_ascii == 8'(v % 10 + 48), tag, unit_ascii, v % 10 + 48);
    endtask

    // Offer one sample and check the flag position, the digits and the hold.
    // With inj set, a competing calibration sample arrives mid-conversion.
    task automatic run(input bit c, input logic [7:0] s, input int exp,
                       input bit inj, input string tag);
        int first = 0;
        int pulses = 0;
        @(negedge clk);
        samp = s; calib = c; samp_vld = 1'b1;
        @(negedge clk);
        samp_vld = 1'b0; calib = 1'b0;
        for (int k = 1; k <= 10; k++) begin
            if (inj && k == 3) begin samp = 8'd50; calib = 1'b1; samp_vld = 1'b1; end
            if (inj && k == 4) begin calib = 1'b0; samp_vld = 1'b0; end
            @(negedge clk);
            if (res_valid) begin
                pulses++;
                if (first == 0) begin
                    first = k;
                    check_digits(exp, tag);
                end
            end
        end
        check(first == 8, {tag, " R6 flag cycle"}, first, 8);
        check(pulses == 1, {tag, " R6/R7 pulse count"}, pulses, 1);
        check_digits(exp, {tag, " R9 hold"});
    endtask

    initial begin
        #(5.0 * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check(res_valid == 1'b0, "R1 valid in reset", res_valid, 0);
        check_digits(0, "R1 digits in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(res_valid == 1'b0, "R1 valid after reset", res_valid, 0);
        check_digits(0, "R1 digits after reset");
        check(frac_ascii == 24'h2E3030, "R5 fraction", frac_ascii, 24'h2E3030);

        for (int i = 0; i < 13; i++)
            run(VEC[i][16], VEC[i][15:8], int'(VEC[i][7:0]), 1'b0, $sformatf("R2/R3/R4/R5 vec%0d", i));

        // R7: competing calibration sample mid-conversion is dropped
        run(1'b0, 8'd80, 80, 1'b1, "R7 busy sample");
        run(1'b0, 8'd40, 40, 1'b0, "R7 zero point kept");

        // R8: calib alone leaves the zero point alone
        @(negedge clk); samp = 8'd90; calib = 1'b1;
        @(negedge clk); calib = 1'b0;
        run(1'b0, 8'd10, 10, 1'b0, "R8 lone calib");
        check(frac_ascii == 24'h2E3030, "R5 fraction later", frac_ascii, 24'h2E3030);

        // R1: reset clears a non-zero zero point
        run(1'b1, 8'd40, 0, 1'b0, "R4 set 40");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check_digits(0, "R1 digits after second reset");
        run(1'b0, 8'd5, 5, 1'b0, "R1 zero point cleared");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule